// File: doc/BRIEF.md
# Interrupt Redirection and Destination Dispatcher

This block sits between a set of interrupt input pins and the fabric that carries interrupt messages to processors. For every pin, a register block elsewhere supplies a redirection entry: mask, vector, delivery mode, destination mode, polarity, trigger mode and an 8-bit destination. When a pin goes from low to high and its entry is not masked, the block queues the pin. It then turns the entry into one delivery message that names the exact set of target processors.

The target set is resolved in one of two ways. In physical mode the destination is a processor ID, and the all-ones value means every processor. In logical mode each processor's logical-destination byte is compared with the destination. Lowest-priority delivery narrows a logical match set to a single processor by rotating through the matches. The message leaves on a valid/ready output. When a message cannot be resolved, the block drops it: an empty target set is discarded without notice, and lowest-priority delivery in physical mode raises a one-cycle error pulse.

Top module: `irq_dispatch`

## Requirements
- R1: After reset `msg_valid` and `cfg_err` are 0, no pin is recorded as high, and the rotation counter is 0. The first lowest-priority message therefore goes to the lowest-numbered matching processor.
- R2: A pin triggers only on a transition from its recorded low state to high. A pin held high never retriggers. Lowering a pin only clears its recorded state and produces no message.
- R3: A rising edge on a pin whose `ent_mask` bit is 1 at that edge is dropped. Clearing the mask later while the pin is still high produces no message.
- R4: When the delivery mode is 3'b111 (external), `msg_vector` equals `ext_vector`. For every other mode it equals the pin's entry vector.
- R5: `msg_mode`, `msg_logical`, `msg_level`, `msg_trigger` and `msg_dest` are copies of the pin entry's delivery mode, destination mode, polarity, trigger mode and destination.
- R6: In physical mode (`ent_logical`=0), destination 8'hFF targets all processors. A destination below NUM_CPUS targets only that processor (bit `dest` of `msg_targets`).
- R7: Delivery mode 3'b001 (lowest priority) with physical destination mode sends nothing. Instead, `cfg_err` is 1 for exactly one cycle.
- R8: In logical mode, processor c is a target when `cpu_ldest[8c+7:8c] & dest` is nonzero.
- R9: For lowest-priority delivery in logical mode with n>0 matches, only the match at position (counter mod n) in ascending processor order is targeted. The 8-bit wrapping counter then increments. Counter value k selects the k-th match, counting from 0.
- R10: A message whose target set is empty is discarded and never shown on the output. This covers a logical mode with no match and a physical ID that is at or above NUM_CPUS but is not 8'hFF.
- R11: Pins that rise together are served one message each, in ascending pin order. Edge recording continues while the output is stalled.
- R12: While `msg_valid`=1 and `msg_ready`=0, the message and its target mask hold unchanged.
- R13: A rise sampled at clock edge k appears on the output after edge k+1 when the output is free. The output is not valid after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pins | input | NUM_PINS | Interrupt input levels |
| ent_mask | input | NUM_PINS | Per-pin mask bit |
| ent_vector | input | NUM_PINS*VEC_W | Per-pin vector, pin p at slice p |
| ent_mode | input | NUM_PINS*3 | Per-pin delivery mode (000 fixed, 001 lowest priority, 111 external) |
| ent_logical | input | NUM_PINS | Per-pin destination mode, 1 = logical |
| ent_polarity | input | NUM_PINS | Per-pin polarity, sent as level bit |
| ent_trigger | input | NUM_PINS | Per-pin trigger mode |
| ent_dest | input | NUM_PINS*DEST_W | Per-pin destination |
| ext_vector | input | VEC_W | Vector from the external interrupt controller |
| cpu_ldest | input | NUM_CPUS*DEST_W | Logical-destination byte of each processor |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_valid | output | 1 | Message present |
| msg_vector | output | VEC_W | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode |
| msg_level | output | 1 | Message level bit |
| msg_trigger | output | 1 | Message trigger mode |
| msg_dest | output | DEST_W | Message destination |
| msg_targets | output | NUM_CPUS | One bit per target processor |
| cfg_err | output | 1 | One-cycle pulse for lowest priority in physical mode |

## Verification
The checker assumes that a pin's entry fields, `ext_vector` and `cpu_ldest` stay stable from the pin's rise until its message has been dispatched. This matters because the entry is read at dispatch time, not at the edge. The bench changes configuration only while no pin is pending. It sweeps every destination value in physical, logical and lowest-priority modes. Stalls and simultaneous rises are tested separately with fixed entries.

// File: rtl/irq_disp_pkg.sv
// Package: delivery-mode encodings shared by the dispatcher and its checker.
package irq_disp_pkg;
    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWEST = 3'b001,
        DM_SMI    = 3'b010,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_EXTINT = 3'b111
    } dlv_mode_e;

    localparam int MODE_W = 3;
endpackage

// File: rtl/irq_edge_capture.sv
// Records each pin's last level and keeps a pending bit per pin for
// unmasked low-to-high changes. Pending bits clear when granted.
// Assumes grant is one-hot or zero.
module irq_edge_capture #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] grant,
    output logic [NUM_PINS-1:0] pending
);
    logic [NUM_PINS-1:0] pin_q;

    // Level history and pending set; history follows pins regardless of stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= '0;
            pending <= '0;
        end else begin
            pin_q   <= pins;
            pending <= (pending & ~grant) | (pins & ~pin_q & ~mask);
        end
    end
endmodule

// File: rtl/irq_pick_lowest.sv
// Fixed-priority picker: lowest-numbered request wins.
// Assumes nothing about req; grant is one-hot or zero.
module irq_pick_lowest #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan downward so the lowest set bit is the final winner.
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_target_resolve.sv
// Turns a destination into a processor target mask: physical ID or
// broadcast, logical byte match, or one rotated pick for lowest priority.
// Assumes NUM_CPUS <= 8 and rot_cnt is supplied by the owner of the counter.
module irq_target_resolve #(
    parameter int NUM_CPUS = 4,
    parameter int DEST_W   = 8,
    parameter int ROT_W    = 8
) (
    input  logic [DEST_W-1:0]          dest,
    input  logic                       logical,
    input  logic                       lowest,
    input  logic [NUM_CPUS*DEST_W-1:0] cpu_ldest,
    input  logic [ROT_W-1:0]           rot_cnt,
    output logic [NUM_CPUS-1:0]        targets,
    output logic                       bad_combo
);
    localparam int CNT_W = $clog2(NUM_CPUS + 1);

    logic [NUM_CPUS-1:0] match, phys, chosen;
    logic [CNT_W-1:0]    nmatch, divisor;
    logic [ROT_W-1:0]    pos;

    // Logical match per processor and match count.
    always_comb begin
        nmatch = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            match[c] = |(cpu_ldest[c*DEST_W +: DEST_W] & dest);
            nmatch   = nmatch + CNT_W'(match[c]);
        end
    end

    // Physical decode: all-ones destination is broadcast.
    always_comb begin
        phys = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (dest == '1 || dest == DEST_W'(c)) phys[c] = 1'b1;
        end
    end

    // Rotated selection among matches in ascending processor order.
    always_comb begin
        logic [CNT_W-1:0] seen;
        divisor = (nmatch == '0) ? CNT_W'(1) : nmatch;
        pos     = rot_cnt % ROT_W'(divisor);
        chosen  = '0;
        seen    = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (match[c]) begin
                if (ROT_W'(seen) == pos) chosen[c] = 1'b1;
                seen = seen + 1'b1;
            end
        end
    end

    // Final target mask per destination mode and delivery mode.
    always_comb begin
        bad_combo = lowest && !logical;
        if (logical) targets = lowest ? chosen : match;
        else         targets = phys;
    end
endmodule

// File: rtl/irq_dispatch.sv
// Top: captures pin edges, serves pending pins in ascending order, builds the
// message from the pin's entry and resolves its targets into a single output
// register with valid/ready. Assumes entry fields are stable while pending.
module irq_dispatch #(
    parameter int NUM_PINS = 8,
    parameter int NUM_CPUS = 4,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 8,
    parameter int ROT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        irq_pins,
    input  logic [NUM_PINS-1:0]        ent_mask,
    input  logic [NUM_PINS*VEC_W-1:0]  ent_vector,
    input  logic [NUM_PINS*3-1:0]      ent_mode,
    input  logic [NUM_PINS-1:0]        ent_logical,
    input  logic [NUM_PINS-1:0]        ent_polarity,
    input  logic [NUM_PINS-1:0]        ent_trigger,
    input  logic [NUM_PINS*DEST_W-1:0] ent_dest,
    input  logic [VEC_W-1:0]           ext_vector,
    input  logic [NUM_CPUS*DEST_W-1:0] cpu_ldest,
    input  logic                       msg_ready,
    output logic                       msg_valid,
    output logic [VEC_W-1:0]           msg_vector,
    output logic [2:0]                 msg_mode,
    output logic                       msg_logical,
    output logic                       msg_level,
    output logic                       msg_trigger,
    output logic [DEST_W-1:0]          msg_dest,
    output logic [NUM_CPUS-1:0]        msg_targets,
    output logic                       cfg_err
);
    import irq_disp_pkg::*;

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] pending, sel_grant, grant;
    logic [IDX_W-1:0]    sel_idx;
    logic                sel_any, load_slot, deliver, bad_combo;
    logic [VEC_W-1:0]    sel_vec;
    logic [2:0]          sel_mode;
    logic                sel_logical, sel_pol, sel_trig;
    logic [DEST_W-1:0]   sel_dest;
    logic [NUM_CPUS-1:0] targets;
    logic [ROT_W-1:0]    rot_cnt;

    irq_edge_capture #(.NUM_PINS(NUM_PINS)) u_capture (
        .clk(clk), .rst_n(rst_n), .pins(irq_pins), .mask(ent_mask),
        .grant(grant), .pending(pending)
    );

    irq_pick_lowest #(.N(NUM_PINS)) u_pick (
        .req(pending), .grant(sel_grant), .idx(sel_idx), .any(sel_any)
    );

    // Output slot can take a new message when empty or being drained.
    assign load_slot = !msg_valid || msg_ready;
    assign grant     = load_slot ? sel_grant : '0;

    // Entry field mux for the selected pin.
    always_comb begin
        sel_vec = '0; sel_mode = '0; sel_logical = 1'b0;
        sel_pol = 1'b0; sel_trig = 1'b0; sel_dest = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (sel_idx == IDX_W'(p)) begin
                sel_vec     = ent_vector[p*VEC_W +: VEC_W];
                sel_mode    = ent_mode[p*3 +: 3];
                sel_logical = ent_logical[p];
                sel_pol     = ent_polarity[p];
                sel_trig    = ent_trigger[p];
                sel_dest    = ent_dest[p*DEST_W +: DEST_W];
            end
        end
    end

    irq_target_resolve #(.NUM_CPUS(NUM_CPUS), .DEST_W(DEST_W), .ROT_W(ROT_W)) u_resolve (
        .dest(sel_dest), .logical(sel_logical), .lowest(sel_mode == DM_LOWEST),
        .cpu_ldest(cpu_ldest), .rot_cnt(rot_cnt),
        .targets(targets), .bad_combo(bad_combo)
    );

    assign deliver = sel_any && load_slot && !bad_combo && (targets != '0);

    // Output register, error pulse and lowest-priority rotation counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid   <= 1'b0;
            msg_vector  <= '0;
            msg_mode    <= '0;
            msg_logical <= 1'b0;
            msg_level   <= 1'b0;
            msg_trigger <= 1'b0;
            msg_dest    <= '0;
            msg_targets <= '0;
            cfg_err     <= 1'b0;
            rot_cnt     <= '0;
        end else begin
            cfg_err <= sel_any && load_slot && bad_combo;
            if (load_slot) msg_valid <= deliver;
            if (deliver) begin
                msg_vector  <= (sel_mode == DM_EXTINT) ? ext_vector : sel_vec;
                msg_mode    <= sel_mode;
                msg_logical <= sel_logical;
                msg_level   <= sel_pol;
                msg_trigger <= sel_trig;
                msg_dest    <= sel_dest;
                msg_targets <= targets;
                if (sel_logical && sel_mode == DM_LOWEST) rot_cnt <= rot_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_dispatch_chk.sv
// Checker for irq_dispatch, attached by bind. Observes only top-level ports.
module irq_dispatch_chk #(
    parameter int NUM_CPUS = 4,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [VEC_W-1:0]    msg_vector,
    input logic [2:0]          msg_mode,
    input logic                msg_logical,
    input logic [DEST_W-1:0]   msg_dest,
    input logic [NUM_CPUS-1:0] msg_targets,
    input logic                cfg_err
);
    import irq_disp_pkg::*;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_targets)
            && $stable(msg_vector) && $stable(msg_dest)); // R12

    AST_NO_EMPTY_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_targets != '0); // R10

    AST_LP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_mode == DM_LOWEST |-> $countones(msg_targets) == 1); // R9

    AST_LP_LOGICAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_mode == DM_LOWEST |-> msg_logical); // R7

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !msg_valid); // R7

    AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_logical && msg_dest == '1 |-> msg_targets == '1); // R6

    AST_PHYS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_logical && msg_dest != '1 |-> $countones(msg_targets) == 1); // R6
endmodule

bind irq_dispatch irq_dispatch_chk #(
    .NUM_CPUS(NUM_CPUS), .VEC_W(VEC_W), .DEST_W(DEST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_logical(msg_logical),
    .msg_dest(msg_dest), .msg_targets(msg_targets), .cfg_err(cfg_err)
);

// File: tb/irq_dispatch_tb.sv
// Bench: sweeps all destinations in each mode, plus masking, edges,
// external vectors, error pulse, stalls and simultaneous rises.
module irq_dispatch_tb;
    localparam int NP = 8;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    irq_pins = '0, ent_mask = '0, ent_logical = '0;
    logic [NP-1:0]    ent_polarity = '0, ent_trigger = '0;
    logic [NP*8-1:0]  ent_vector = '0, ent_dest = '0;
    logic [NP*3-1:0]  ent_mode = '0;
    logic [7:0]       ext_vector = 8'h00;
    logic [NC*8-1:0]  cpu_ldest = {8'h81, 8'h30, 8'h06, 8'h01};
    logic             msg_ready = 1'b1;
    logic             msg_valid, msg_logical, msg_level, msg_trigger, cfg_err;
    logic [7:0]       msg_vector, msg_dest;
    logic [2:0]       msg_mode;
    logic [NC-1:0]    msg_targets;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Sampled results of one send
    logic       s_early, s_valid, s_err;
    logic [7:0] s_vec, s_dest;
    logic [2:0] s_mode;
    logic       s_log, s_lvl, s_trg;
    logic [NC-1:0] s_tg;
    logic [7:0] lp_cnt = 8'd0;

    irq_dispatch #(.NUM_PINS(NP), .NUM_CPUS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .ent_mask(ent_mask),
        .ent_vector(ent_vector), .ent_mode(ent_mode), .ent_logical(ent_logical),
        .ent_polarity(ent_polarity), .ent_trigger(ent_trigger), .ent_dest(ent_dest),
        .ext_vector(ext_vector), .cpu_ldest(cpu_ldest), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_logical(msg_logical), .msg_level(msg_level), .msg_trigger(msg_trigger),
        .msg_dest(msg_dest), .msg_targets(msg_targets), .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic cfg(input int p, input logic [7:0] vec, input logic [2:0] mode,
                       input bit lg, input bit pol, input bit trg, input logic [7:0] dst);
        ent_vector[p*8 +: 8] = vec;
        ent_mode[p*3 +: 3]   = mode;
        ent_logical[p]       = lg;
        ent_polarity[p]      = pol;
        ent_trigger[p]       = trg;
        ent_dest[p*8 +: 8]   = dst;
    endtask

    // Raise pin p, sample after one and two edges, then lower it.
    task automatic send_one(input int p);
        @(negedge clk) irq_pins[p] = 1'b1;
        @(negedge clk) s_early = msg_valid;
        @(negedge clk);
        s_valid = msg_valid; s_err = cfg_err; s_vec = msg_vector; s_dest = msg_dest;
        s_mode = msg_mode; s_log = msg_logical; s_lvl = msg_level; s_trg = msg_trigger;
        s_tg = msg_targets;
        irq_pins[p] = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [NC-1:0] exp_phys(input logic [7:0] d);
        if (d == 8'hFF) return '1;
        if (d < NC) return NC'(1) << d;
        return '0;
    endfunction

    function automatic logic [NC-1:0] exp_match(input logic [7:0] d);
        logic [NC-1:0] m;
        for (int c = 0; c < NC; c++) m[c] = (cpu_ldest[c*8 +: 8] & d) != 8'h00;
        return m;
    endfunction

    function automatic logic [NC-1:0] exp_pick(input logic [NC-1:0] m, input logic [7:0] cnt);
        int n, k, seen;
        logic [NC-1:0] r;
        n = 0; r = '0; seen = 0;
        for (int c = 0; c < NC; c++) n += int'(m[c]);
        if (n == 0) return '0;
        k = int'(cnt) % n;
        for (int c = 0; c < NC; c++) begin
            if (m[c]) begin
                if (seen == k) r[c] = 1'b1;
                seen++;
            end
        end
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] t;
        for (int p = 0; p < NP; p++) cfg(p, 8'h20 + 8'(p), 3'b000, 1'b0, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(msg_valid == 1'b0, "R1", "valid in reset", msg_valid, 0);
        chk(cfg_err == 1'b0, "R1", "err in reset", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(msg_valid == 1'b0, "R1", "valid after reset", msg_valid, 0);

        // R6/R10/R13: physical fixed sweep over all destinations
        for (int d = 0; d < 256; d++) begin
            cfg(0, 8'h40, 3'b000, 1'b0, 1'b0, 1'b0, 8'(d));
            send_one(0);
            t = exp_phys(8'(d));
            chk(s_early == 1'b0, "R13", "valid one edge after rise", s_early, 0);
            chk(s_valid == (t != '0), "R10", "physical valid", s_valid, int'(t != '0));
            if (t != '0) chk(s_tg == t, "R6", "physical targets", s_tg, t);
        end

        // R8/R10: logical fixed sweep
        for (int d = 0; d < 256; d++) begin
            cfg(1, 8'h41, 3'b000, 1'b1, 1'b0, 1'b0, 8'(d));
            send_one(1);
            t = exp_match(8'(d));
            chk(s_valid == (t != '0), "R10", "logical valid", s_valid, int'(t != '0));
            if (t != '0) chk(s_tg == t, "R8", "logical targets", s_tg, t);
        end

        // R9/R1: lowest-priority logical sweep with rotation model from 0
        for (int d = 0; d < 256; d++) begin
            cfg(2, 8'h42, 3'b001, 1'b1, 1'b0, 1'b0, 8'(d));
            send_one(2);
            t = exp_pick(exp_match(8'(d)), lp_cnt);
            chk(s_valid == (t != '0), "R9", "lowest valid", s_valid, int'(t != '0));
            if (t != '0) begin
                chk(s_tg == t, "R9", "lowest pick", s_tg, t);
                lp_cnt = lp_cnt + 8'd1;
            end
        end

        // R4/R5: external vector and field copies
        ext_vector = 8'h9C;
        cfg(4, 8'h33, 3'b111, 1'b0, 1'b1, 1'b1, 8'h01);
        send_one(4);
        chk(s_valid && s_vec == 8'h9C, "R4", "external vector", s_vec, 8'h9C);
        chk(s_mode == 3'b111, "R5", "mode copy", s_mode, 7);
        chk(s_lvl == 1'b1 && s_trg == 1'b1, "R5", "level/trigger copy", {s_lvl, s_trg}, 3);
        chk(s_dest == 8'h01 && s_log == 1'b0, "R5", "dest copy", s_dest, 1);
        cfg(4, 8'h33, 3'b000, 1'b1, 1'b1, 1'b0, 8'h06);
        send_one(4);
        chk(s_valid && s_vec == 8'h33, "R4", "entry vector", s_vec, 8'h33);
        chk(s_log == 1'b1 && s_lvl == 1'b1 && s_trg == 1'b0, "R5", "mode bits copy",
            {s_log, s_lvl, s_trg}, 6);

        // R7: lowest priority with physical mode
        cfg(5, 8'h55, 3'b001, 1'b0, 1'b0, 1'b0, 8'h00);
        send_one(5);
        chk(s_err == 1'b1 && s_valid == 1'b0, "R7", "error pulse, no send", {s_err, s_valid}, 2);
        chk(cfg_err == 1'b0, "R7", "error one cycle", cfg_err, 0);

        // R3/R2: masked edge dropped, unmask while high gives nothing
        cfg(3, 8'h66, 3'b000, 1'b0, 1'b0, 1'b0, 8'h02);
        ent_mask[3] = 1'b1;
        send_one(3);
        chk(s_valid == 1'b0, "R3", "masked edge", s_valid, 0);
        @(negedge clk) irq_pins[3] = 1'b1;
        @(negedge clk) ent_mask[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk(msg_valid == 1'b0, "R3", "unmask while high", msg_valid, 0);
        irq_pins[3] = 1'b0;
        @(negedge clk);
        send_one(3);
        chk(s_valid == 1'b1 && s_vec == 8'h66, "R3", "unmasked edge", s_vec, 8'h66);

        // R2: held high does not retrigger; falling edge silent
        @(negedge clk) irq_pins[6] = 1'b1;
        cfg(6, 8'h77, 3'b000, 1'b0, 1'b0, 1'b0, 8'h03);
        repeat (2) @(negedge clk);
        chk(msg_valid == 1'b1, "R2", "first edge", msg_valid, 1);
        repeat (4) @(negedge clk);
        chk(msg_valid == 1'b0, "R2", "held high", msg_valid, 0);
        irq_pins[6] = 1'b0;
        repeat (3) @(negedge clk);
        chk(msg_valid == 1'b0, "R2", "falling edge", msg_valid, 0);

        // R11/R12: simultaneous rises under backpressure
        cfg(1, 8'hA1, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00);
        cfg(3, 8'hA3, 3'b000, 1'b0, 1'b0, 1'b0, 8'h01);
        cfg(6, 8'hA6, 3'b000, 1'b0, 1'b0, 1'b0, 8'h02);
        msg_ready = 1'b0;
        @(negedge clk) irq_pins = 8'b0100_1010;
        repeat (2) @(negedge clk);
        chk(msg_valid && msg_vector == 8'hA1, "R11", "first served pin 1", msg_vector, 8'hA1);
        repeat (3) @(negedge clk);
        chk(msg_valid && msg_vector == 8'hA1 && msg_targets == 4'b0001, "R12",
            "held under stall", msg_vector, 8'hA1);
        msg_ready = 1'b1;
        @(negedge clk);
        chk(msg_valid && msg_vector == 8'hA3, "R11", "second pin 3", msg_vector, 8'hA3);
        @(negedge clk);
        chk(msg_valid && msg_vector == 8'hA6, "R11", "third pin 6", msg_vector, 8'hA6);
        @(negedge clk);
        chk(msg_valid == 1'b0, "R11", "no retrigger after stall", msg_valid, 0);
        irq_pins = '0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule